// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block holds the 64-byte standard configuration header of one PCI function. A requester issues a single read or write at a byte offset with a size of one, two or four bytes. The block answers with exactly one response a fixed number of clock edges later. Identification and fixed fields come from parameters and are loaded at reset. A small set of registers can be written, and which ones depends on the access size.

Each of the six base address registers (BARs) takes part in the sizing handshake that software uses. A BAR keeps its I/O or memory attribute bits whatever is written to it. When a BAR receives a new non-zero base, that base goes out on a per-BAR decode bus and a one-cycle range-changed pulse tells the address decoder to reload. A BAR can be configured as legacy I/O. Such a BAR reads as zero and keeps its decode base fixed. The expansion ROM register has its own probe value.

Top module: `pci_cfg_hdr`

## Requirements
- R1: A request whose req_size_i is not 1, 2 or 4 gets a response with rsp_err_o high and zero data, and changes no register.
- R2: A request at an offset of 0x40 or above, or one whose bytes would extend past offset 0x3F, gets an error response and changes no register.
- R3: A one-byte write stores req_wdata_i[7:0] at interrupt line (0x3C), cache line size (0x0C) or latency timer (0x0D). At revision (0x08), class (0x0B), interrupt pin (0x3D), minimum grant (0x3E) or maximum latency (0x3F) it completes without error and stores nothing. At any other offset it is an error.
- R4: A two-byte write stores req_wdata_i[15:0] into command (0x04) or status (0x06). At 0x0C it stores req_wdata_i[7:0] into cache line size only. At any other offset it is an error.
- R5: A four-byte write at 0x04 stores req_wdata_i[15:0] into command and req_wdata_i[31:16] into status. A four-byte write at any offset that is neither a BAR nor the ROM register completes without error and stores nothing.
- R6: A four-byte write of 0xFFFFFFFF to a non-legacy BAR (aligned offsets 0x10 to 0x24) loads it with ~(size-1) in the upper bits and leaves the attribute bits unchanged. A BAR of size zero therefore reads back only its attribute bits.
- R7: Any other four-byte BAR write takes the upper bits from req_wdata_i and keeps the old low attribute bits. An I/O BAR (bit 0 set) keeps bits 1:0, and a memory BAR keeps bits 3:0.
- R8: If the upper bits of such a write are non-zero, that BAR's 32-bit slice of bar_base_o takes them, and in the cycle after acceptance range_chg_o pulses with range_bar_o one-hot on that BAR. A zero base changes neither.
- R9: A four-byte write of 0xFFFFFFFE to the ROM register (0x30) stores 0xFFFFFFFF. Any other value is stored as written.
- R10: A legacy BAR reads as zero, ignores writes without error, never pulses range_chg_o, and keeps its reset value on bar_base_o. A non-legacy BAR resets to a decode base of zero.
- R11: A read returns the header bytes starting at the offset, little-endian and right-justified in rsp_rdata_o, with the unused upper bytes zero. The header follows the standard Type 0 layout, with the parameter values loaded at reset.
- R12: A request is accepted when req_valid_i and req_ready_o are both high. rsp_valid_o is high for exactly one cycle, CFG_LATENCY rising edges after the accepting edge. req_ready_o stays low from acceptance until the edge that ends the response cycle. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 8 | Byte offset into configuration space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-justified |
| rsp_valid_o | output | 1 | Response present for one cycle |
| rsp_err_o | output | 1 | Request was rejected |
| rsp_rdata_o | output | 32 | Read data, right-justified |
| bar_base_o | output | 192 | Decode base of each BAR, BAR n in bits 32n+31:32n |
| range_chg_o | output | 1 | Pulse: a BAR decode base changed |
| range_bar_o | output | 6 | One-hot BAR whose base changed |

## Verification
The embedded assertions check several properties on every cycle:
- a response never lasts more than one cycle, and an accepted request drops req_ready_o;
- a BAR write never disturbs the attribute bits;
- a range pulse always points at a single BAR with a non-zero base;
- a rejected request leaves every writable register and the range pulse untouched;
- the ROM probe value always lands as all-ones.

Only the bench scenarios can show the rest:
- the exact latency of each response;
- the size-dependent write whitelist;
- the probe masks for each BAR size and type, and the legacy BAR behaviour;
- the read data assembled for unaligned and mixed-size reads.

For these, a behavioural model of the header predicts every response and every decode base on each cycle.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int HDR_BYTES = 64;
  localparam int NUM_BAR   = 6;
  localparam int BAR_IW    = 3;

  localparam logic [7:0] OFF_VENDOR = 8'h00;
  localparam logic [7:0] OFF_DEVICE = 8'h02;
  localparam logic [7:0] OFF_CMD    = 8'h04;
  localparam logic [7:0] OFF_STAT   = 8'h06;
  localparam logic [7:0] OFF_REV    = 8'h08;
  localparam logic [7:0] OFF_PROG   = 8'h09;
  localparam logic [7:0] OFF_SUBCLS = 8'h0A;
  localparam logic [7:0] OFF_CLASS  = 8'h0B;
  localparam logic [7:0] OFF_CLS    = 8'h0C;
  localparam logic [7:0] OFF_LAT    = 8'h0D;
  localparam logic [7:0] OFF_HDR    = 8'h0E;
  localparam logic [7:0] OFF_BAR0   = 8'h10;
  localparam logic [7:0] OFF_SSVID  = 8'h2C;
  localparam logic [7:0] OFF_SSID   = 8'h2E;
  localparam logic [7:0] OFF_ROM    = 8'h30;
  localparam logic [7:0] OFF_ILINE  = 8'h3C;
  localparam logic [7:0] OFF_IPIN   = 8'h3D;
  localparam logic [7:0] OFF_MINGNT = 8'h3E;
  localparam logic [7:0] OFF_MAXLAT = 8'h3F;

  typedef enum logic [3:0] {
    WA_NONE,
    WA_ILINE,
    WA_CLS,
    WA_LAT,
    WA_CMD16,
    WA_STAT16,
    WA_CMD32,
    WA_BAR,
    WA_ROM
  } wr_act_e;

  typedef struct packed {
    logic              err;
    wr_act_e           act;
    logic [BAR_IW-1:0] bar_idx;
  } acc_dec_t;
endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode import pci_cfg_pkg::*; (
  input  logic       write_i,
  input  logic [7:0] offset_i,
  input  logic [2:0] size_i,
  output acc_dec_t   dec_o
);
  logic [8:0] end_w;
  logic       size_ok;
  logic       bound_err;
  logic       in_bar;
  logic [7:0] bar_rel;

  assign end_w     = {1'b0, offset_i} + {6'b0, size_i};
  assign size_ok   = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  assign bound_err = end_w > 9'(HDR_BYTES);
  assign bar_rel   = offset_i - OFF_BAR0;
  assign in_bar    = (offset_i >= OFF_BAR0) && (offset_i < OFF_BAR0 + 8'(4 * NUM_BAR))
                     && (offset_i[1:0] == 2'b00);

  always_comb begin
    dec_o.err     = ~size_ok | bound_err;
    dec_o.act     = WA_NONE;
    dec_o.bar_idx = '0;
    if (write_i && !dec_o.err) begin
      unique case (size_i)
        3'd1: begin
          unique case (offset_i)
            OFF_ILINE: dec_o.act = WA_ILINE;
            OFF_CLS:   dec_o.act = WA_CLS;
            OFF_LAT:   dec_o.act = WA_LAT;
            OFF_IPIN, OFF_MINGNT, OFF_MAXLAT, OFF_CLASS, OFF_REV: dec_o.act = WA_NONE;
            default:   dec_o.err = 1'b1;
          endcase
        end
        3'd2: begin
          unique case (offset_i)
            OFF_CMD:  dec_o.act = WA_CMD16;
            OFF_STAT: dec_o.act = WA_STAT16;
            OFF_CLS:  dec_o.act = WA_CLS;
            default:  dec_o.err = 1'b1;
          endcase
        end
        default: begin
          if (in_bar) begin
            dec_o.act     = WA_BAR;
            dec_o.bar_idx = BAR_IW'(bar_rel >> 2);
          end else if (offset_i == OFF_ROM) begin
            dec_o.act = WA_ROM;
          end else if (offset_i == OFF_CMD) begin
            dec_o.act = WA_CMD32;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pci_cfg_bar_slot.sv
module pci_cfg_bar_slot #(
  parameter bit          LEGACY    = 1'b0,
  parameter logic [31:0] BAR_SIZE  = 32'h0000_1000,
  parameter logic [31:0] BAR_RESET = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] bar_o,
  output logic [31:0] base_o,
  output logic        chg_o
);
  localparam logic [31:0] PROBE_MASK = ~(BAR_SIZE - 32'd1);

  if (LEGACY) begin : g_legacy
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, wr_i, wdata_i};
    assign bar_o  = '0;
    assign base_o = BAR_RESET;
    assign chg_o  = 1'b0;
  end else begin : g_live
    logic [31:0] bar_q, base_q;
    logic        chg_q;
    logic [31:0] attr_mask, new_hi;
    logic        probe, base_upd;

    assign attr_mask = bar_q[0] ? 32'h0000_0003 : 32'h0000_000F;
    assign probe     = &wdata_i;
    assign new_hi    = (probe ? PROBE_MASK : wdata_i) & ~attr_mask;
    assign base_upd  = wr_i && !probe && (new_hi != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bar_q  <= BAR_RESET;
        base_q <= '0;
        chg_q  <= 1'b0;
      end else begin
        chg_q <= base_upd;
        if (wr_i)     bar_q  <= new_hi | (bar_q & attr_mask);
        if (base_upd) base_q <= new_hi;
      end
    end

    assign bar_o  = bar_q;
    assign base_o = base_q;
    assign chg_o  = chg_q;

    AST_BAR_ATTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((bar_q & $past(attr_mask)) == ($past(bar_q) & $past(attr_mask)))); // R7
    AST_BASE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_q |-> (base_q != '0)); // R8
  end
endmodule

// File: rtl/pci_cfg_rsp_timer.sv
module pci_cfg_rsp_timer #(
  parameter int unsigned LATENCY = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        accept_i,
  input  logic        err_i,
  input  logic [31:0] rdata_i,
  output logic        ready_o,
  output logic        rsp_valid_o,
  output logic        rsp_err_o,
  output logic [31:0] rsp_rdata_o
);
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;

  logic          busy_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   data_q;

  assign rsp_valid_o = busy_q && (cnt_q == '0);
  assign ready_o     = ~busy_q;
  assign rsp_err_o   = rsp_valid_o & err_q;
  assign rsp_rdata_o = rsp_valid_o ? data_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      err_q  <= err_i;
      cnt_q  <= CW'(LATENCY - 1);
      data_q <= err_i ? '0 : rdata_i;
    end else if (rsp_valid_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R12
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !ready_o); // R12
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr import pci_cfg_pkg::*; #(
  parameter int unsigned CFG_LATENCY      = 2,
  parameter logic [15:0] VENDOR_ID        = 16'hABCD,
  parameter logic [15:0] DEVICE_ID        = 16'h0123,
  parameter logic [7:0]  REVISION_ID      = 8'h01,
  parameter logic [23:0] CLASS_CODE       = 24'h020000,
  parameter logic [7:0]  HEADER_TYPE      = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID        = 16'h0000,
  parameter logic [7:0]  INT_LINE_INIT    = 8'h00,
  parameter logic [7:0]  INT_PIN          = 8'h01,
  parameter logic [7:0]  MIN_GRANT        = 8'h00,
  parameter logic [7:0]  MAX_LATENCY      = 8'h00,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h1000},
  parameter logic [NUM_BAR*32-1:0] BAR_INIT = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0},
  parameter logic [NUM_BAR-1:0]    BAR_LEGACY = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [7:0]            req_offset_i,
  input  logic [2:0]            req_size_i,
  input  logic [31:0]           req_wdata_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_err_o,
  output logic [31:0]           rsp_rdata_o,
  output logic [NUM_BAR*32-1:0] bar_base_o,
  output logic                  range_chg_o,
  output logic [NUM_BAR-1:0]    range_bar_o
);
  acc_dec_t dec;
  logic     accept, do_wr;

  pci_cfg_decode u_dec (
    .write_i (req_write_i),
    .offset_i(req_offset_i),
    .size_i  (req_size_i),
    .dec_o   (dec)
  );

  assign accept = req_valid_i & req_ready_o;
  assign do_wr  = accept & req_write_i & ~dec.err;

  logic [31:0]        bar_rd [NUM_BAR];
  logic [NUM_BAR-1:0] bar_chg;

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    pci_cfg_bar_slot #(
      .LEGACY   (BAR_LEGACY[g]),
      .BAR_SIZE (BAR_SIZE[g*32 +: 32]),
      .BAR_RESET(BAR_INIT[g*32 +: 32])
    ) u_bar (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (do_wr && (dec.act == WA_BAR) && (dec.bar_idx == BAR_IW'(g))),
      .wdata_i(req_wdata_i),
      .bar_o  (bar_rd[g]),
      .base_o (bar_base_o[g*32 +: 32]),
      .chg_o  (bar_chg[g])
    );
  end

  assign range_bar_o = bar_chg;
  assign range_chg_o = |bar_chg;

  logic [15:0] cmd_q, stat_q;
  logic [7:0]  cls_q, lat_q, iline_q;
  logic [31:0] rom_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      cls_q   <= '0;
      lat_q   <= '0;
      iline_q <= INT_LINE_INIT;
      rom_q   <= '0;
    end else if (do_wr) begin
      unique case (dec.act)
        WA_ILINE:  iline_q <= req_wdata_i[7:0];
        WA_CLS:    cls_q   <= req_wdata_i[7:0];
        WA_LAT:    lat_q   <= req_wdata_i[7:0];
        WA_CMD16:  cmd_q   <= req_wdata_i[15:0];
        WA_STAT16: stat_q  <= req_wdata_i[15:0];
        WA_CMD32: begin
          cmd_q  <= req_wdata_i[15:0];
          stat_q <= req_wdata_i[31:16];
        end
        WA_ROM:    rom_q <= (req_wdata_i == 32'hFFFF_FFFE) ? '1 : req_wdata_i;
        default: ;
      endcase
    end
  end

  // Byte image of the header
  logic [7:0] hdr_b [HDR_BYTES];
  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) hdr_b[i] = '0;
    hdr_b[OFF_VENDOR]     = VENDOR_ID[7:0];
    hdr_b[OFF_VENDOR + 1] = VENDOR_ID[15:8];
    hdr_b[OFF_DEVICE]     = DEVICE_ID[7:0];
    hdr_b[OFF_DEVICE + 1] = DEVICE_ID[15:8];
    hdr_b[OFF_CMD]        = cmd_q[7:0];
    hdr_b[OFF_CMD + 1]    = cmd_q[15:8];
    hdr_b[OFF_STAT]       = stat_q[7:0];
    hdr_b[OFF_STAT + 1]   = stat_q[15:8];
    hdr_b[OFF_REV]        = REVISION_ID;
    hdr_b[OFF_PROG]       = CLASS_CODE[7:0];
    hdr_b[OFF_SUBCLS]     = CLASS_CODE[15:8];
    hdr_b[OFF_CLASS]      = CLASS_CODE[23:16];
    hdr_b[OFF_CLS]        = cls_q;
    hdr_b[OFF_LAT]        = lat_q;
    hdr_b[OFF_HDR]        = HEADER_TYPE;
    for (int b = 0; b < NUM_BAR; b++)
      for (int k = 0; k < 4; k++)
        hdr_b[int'(OFF_BAR0) + 4*b + k] = bar_rd[b][8*k +: 8];
    hdr_b[OFF_SSVID]      = SUBSYS_VENDOR_ID[7:0];
    hdr_b[OFF_SSVID + 1]  = SUBSYS_VENDOR_ID[15:8];
    hdr_b[OFF_SSID]       = SUBSYS_ID[7:0];
    hdr_b[OFF_SSID + 1]   = SUBSYS_ID[15:8];
    for (int k = 0; k < 4; k++) hdr_b[int'(OFF_ROM) + k] = rom_q[8*k +: 8];
    hdr_b[OFF_ILINE]      = iline_q;
    hdr_b[OFF_IPIN]       = INT_PIN;
    hdr_b[OFF_MINGNT]     = MIN_GRANT;
    hdr_b[OFF_MAXLAT]     = MAX_LATENCY;
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(req_size_i))
        rd_word[8*k +: 8] = hdr_b[req_offset_i[5:0] + 6'(k)];
  end

  pci_cfg_rsp_timer #(.LATENCY(CFG_LATENCY)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .err_i      (dec.err),
    .rdata_i    (req_write_i ? 32'h0 : rd_word),
    .ready_o    (req_ready_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  AST_ERR_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec.err) |=> ($stable(cmd_q) && $stable(stat_q) && $stable(cls_q) &&
                             $stable(lat_q) && $stable(iline_q) && $stable(rom_q) &&
                             !range_chg_o)); // R1
  AST_RANGE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(range_bar_o)); // R8
  AST_ROM_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_write_i && req_size_i == 3'd4 && req_offset_i == OFF_ROM &&
     req_wdata_i == 32'hFFFF_FFFE) |=> (rom_q == 32'hFFFF_FFFF)); // R9
endmodule

// File: tb/sim_pci_cfg_hdr.sv
`timescale 1ns/1ps
module sim_pci_cfg_hdr;
  localparam int          LAT    = 3;
  localparam logic [15:0] VID    = 16'h1D0F;
  localparam logic [15:0] DID    = 16'h7A31;
  localparam logic [7:0]  REV    = 8'h05;
  localparam logic [23:0] CLS    = 24'h0C0330;
  localparam logic [7:0]  HTYPE  = 8'h00;
  localparam logic [15:0] SSVID  = 16'h5A5A;
  localparam logic [15:0] SSID   = 16'hC3C3;
  localparam logic [7:0]  ILINE  = 8'h0B;
  localparam logic [7:0]  IPIN   = 8'h02;
  localparam logic [7:0]  MGNT   = 8'h03;
  localparam logic [7:0]  MLAT   = 8'h40;
  localparam logic [191:0] SIZES = {32'h80, 32'h10000, 32'h0, 32'h8, 32'h100, 32'h1000};
  localparam logic [191:0] INITS = {32'h0, 32'hC, 32'h0, 32'h3F8, 32'h1, 32'h8};
  localparam logic [5:0]   LEGS  = 6'b000100;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_off = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [191:0] bar_base;
  logic range_chg;
  logic [5:0] range_bar;

  always #4 clk = ~clk;

  pci_cfg_hdr #(
    .CFG_LATENCY(LAT), .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION_ID(REV),
    .CLASS_CODE(CLS), .HEADER_TYPE(HTYPE), .SUBSYS_VENDOR_ID(SSVID), .SUBSYS_ID(SSID),
    .INT_LINE_INIT(ILINE), .INT_PIN(IPIN), .MIN_GRANT(MGNT), .MAX_LATENCY(MLAT),
    .BAR_SIZE(SIZES), .BAR_INIT(INITS), .BAR_LEGACY(LEGS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_offset_i(req_off), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .bar_base_o(bar_base), .range_chg_o(range_chg),
    .range_bar_o(range_bar)
  );

  int checks = 0, errors = 0;
  bit done = 0, in_txn = 0;

  // Reference model state
  logic [7:0]  m [64];
  logic [31:0] bsz [6];
  logic [31:0] bbase [6];
  bit          bleg [6];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int o);
    return {m[o+3], m[o+2], m[o+1], m[o]};
  endfunction

  function automatic void wr32(input int o, input logic [31:0] v);
    for (int k = 0; k < 4; k++) m[o+k] = v[8*k +: 8];
  endfunction

  function automatic void model_init();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    m[0] = VID[7:0];  m[1] = VID[15:8];
    m[2] = DID[7:0];  m[3] = DID[15:8];
    m[8] = REV; m[9] = CLS[7:0]; m[10] = CLS[15:8]; m[11] = CLS[23:16];
    m[14] = HTYPE;
    m[44] = SSVID[7:0]; m[45] = SSVID[15:8];
    m[46] = SSID[7:0];  m[47] = SSID[15:8];
    m[60] = ILINE; m[61] = IPIN; m[62] = MGNT; m[63] = MLAT;
    for (int b = 0; b < 6; b++) begin
      bsz[b]  = SIZES[b*32 +: 32];
      bleg[b] = LEGS[b];
      bbase[b] = bleg[b] ? INITS[b*32 +: 32] : 32'h0;
      if (!bleg[b]) wr32(16 + 4*b, INITS[b*32 +: 32]);
    end
  endfunction

  function automatic void model_req(input bit wr, input int off, input int sz,
                                    input logic [31:0] wd, output bit er,
                                    output logic [31:0] rd, output logic [5:0] chg);
    logic [31:0] old, mask, nw;
    int b;
    er = 0; rd = 0; chg = 0;
    if (!(sz == 1 || sz == 2 || sz == 4) || off + sz > 64) begin
      er = 1;
      return;
    end
    if (!wr) begin
      for (int k = 0; k < sz; k++) rd[8*k +: 8] = m[off+k];
      return;
    end
    if (sz == 1) begin
      if (off == 60 || off == 12 || off == 13) m[off] = wd[7:0];
      else if (!(off == 61 || off == 62 || off == 63 || off == 11 || off == 8)) er = 1;
    end else if (sz == 2) begin
      if (off == 4 || off == 6) begin m[off] = wd[7:0]; m[off+1] = wd[15:8]; end
      else if (off == 12) m[12] = wd[7:0];
      else er = 1;
    end else begin
      if (off >= 16 && off < 40 && off % 4 == 0) begin
        b = (off - 16) / 4;
        if (!bleg[b]) begin
          old  = rd32(off);
          mask = old[0] ? 32'h3 : 32'hF;
          if (wd == 32'hFFFF_FFFF) nw = ~(bsz[b] - 32'd1) & ~mask;
          else begin
            nw = wd & ~mask;
            if (nw != 0) begin bbase[b] = nw; chg[b] = 1'b1; end
          end
          wr32(off, nw | (old & mask));
        end
      end else if (off == 48) wr32(48, (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd);
      else if (off == 4) wr32(4, wd);
    end
  endfunction

  task automatic xact(input bit wr, input int off, input int sz, input logic [31:0] wd,
                      input string rq);
    bit e_er, a_er, tm_ok;
    logic [31:0] e_rd, a_rd;
    logic [5:0] e_chg;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_off = 8'(off); req_size = 3'(sz); req_wdata = wd;
    @(posedge clk);
    in_txn = 1;
    model_req(wr, off, sz, wd, e_er, e_rd, e_chg);
    @(negedge clk);
    req_valid = 0;
    tm_ok = (req_ready === 1'b0);
    chk(range_bar === e_chg && range_chg === (|e_chg), {rq, " range pulse R8"},
        {26'b0, range_bar}, {26'b0, e_chg});
    a_er = 0; a_rd = 0;
    for (int k = 1; k <= LAT; k++) begin
      if (k > 1) @(negedge clk);
      if (rsp_valid !== (k == LAT)) tm_ok = 0;
      if (k == LAT) begin a_er = rsp_err; a_rd = rsp_rdata; end
    end
    @(negedge clk);
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) tm_ok = 0;
    in_txn = 0;
    chk(tm_ok, {rq, " response timing R12"}, {31'b0, tm_ok}, 32'h1);
    chk(a_er === e_er, {rq, " error flag"}, {31'b0, a_er}, {31'b0, e_er});
    chk(a_rd === e_rd, {rq, " data"}, a_rd, e_rd);
  endtask

  // Per-clock comparison of idle response and decode bases against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!in_txn) chk(rsp_valid === 1'b0, "R12 idle no response", {31'b0, rsp_valid}, 32'h0);
      for (int b = 0; b < 6; b++)
        chk(bar_base[b*32 +: 32] === bbase[b], "R8 R10 decode base",
            bar_base[b*32 +: 32], bbase[b]);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R12 reset handshake",
        {30'b0, req_ready, rsp_valid}, 32'h2);
    chk(range_chg === 1'b0, "R8 reset no pulse", {31'b0, range_chg}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R11 identification reads
    xact(0, 0, 4, 0, "R11 id dword");
    xact(0, 8'h0B, 1, 0, "R11 class byte");
    xact(0, 8'h0A, 2, 0, "R11 subclass half");
    xact(0, 8'h3D, 1, 0, "R11 int pin");
    xact(0, 8'h2C, 4, 0, "R11 subsystem");
    xact(0, 8'h3C, 4, 0, "R11 int dword");
    xact(0, 8'h01, 2, 0, "R11 unaligned half");
    // R1 / R2 errors
    xact(0, 0, 3, 0, "R1 size 3 read");
    xact(1, 8'h3C, 0, 32'h77, "R1 size 0 write");
    xact(1, 8'h04, 5, 32'hFFFF, "R1 size 5 write");
    xact(0, 8'h40, 1, 0, "R2 offset 0x40");
    xact(0, 8'h3E, 4, 0, "R2 crossing read");
    xact(1, 8'h80, 4, 32'h1234, "R2 high write");
    // R3 byte writes
    xact(1, 8'h3C, 1, 32'hAB, "R3 int line");
    xact(1, 8'h0C, 1, 32'h10, "R3 cache line");
    xact(1, 8'h0D, 1, 32'h20, "R3 latency timer");
    xact(1, 8'h08, 1, 32'h99, "R3 revision ignored");
    xact(1, 8'h3F, 1, 32'h99, "R3 max lat ignored");
    xact(1, 8'h00, 1, 32'h99, "R3 vendor error");
    xact(0, 8'h0C, 4, 0, "R3 readback");
    xact(0, 8'h3C, 4, 0, "R3 readback tail");
    // R4 halfword writes
    xact(1, 8'h04, 2, 32'h0147, "R4 command");
    xact(1, 8'h06, 2, 32'hBEEF, "R4 status");
    xact(1, 8'h0C, 2, 32'h55AA, "R4 cache line half");
    xact(1, 8'h08, 2, 32'h1111, "R4 revision error");
    xact(0, 8'h04, 4, 0, "R4 readback");
    xact(0, 8'h0C, 2, 0, "R4 cls readback");
    // R5 dword writes
    xact(1, 8'h04, 4, 32'h1234_5678, "R5 command dword");
    xact(1, 8'h00, 4, 32'hDEAD_BEEF, "R5 id ignored");
    xact(1, 8'h2C, 4, 32'hDEAD_BEEF, "R5 subsystem ignored");
    xact(0, 8'h00, 4, 0, "R5 id readback");
    xact(0, 8'h04, 4, 0, "R5 command readback");
    // R6 probes
    xact(1, 8'h10, 4, 32'hFFFF_FFFF, "R6 probe mem");
    xact(0, 8'h10, 4, 0, "R6 probe mem read");
    xact(1, 8'h14, 4, 32'hFFFF_FFFF, "R6 probe io");
    xact(0, 8'h14, 4, 0, "R6 probe io read");
    xact(1, 8'h1C, 4, 32'hFFFF_FFFF, "R6 probe size zero");
    xact(0, 8'h1C, 4, 0, "R6 size zero read");
    xact(1, 8'h20, 4, 32'hFFFF_FFFF, "R6 probe bar4");
    xact(0, 8'h20, 4, 0, "R6 bar4 read");
    // R7 / R8 base writes
    xact(1, 8'h10, 4, 32'hA000_0007, "R7 mem base");
    xact(0, 8'h10, 4, 0, "R7 mem read");
    xact(1, 8'h14, 4, 32'h0000_C0FE, "R7 io base");
    xact(0, 8'h14, 4, 0, "R7 io read");
    xact(1, 8'h24, 4, 32'h8765_4321, "R8 bar5 base");
    xact(1, 8'h20, 4, 32'h0000_0005, "R8 zero base");
    xact(0, 8'h20, 4, 0, "R8 zero base read");
    xact(1, 8'h14, 4, 32'h0000_0002, "R8 io zero base");
    xact(0, 8'h12, 2, 0, "R7 upper half read");
    // R9 ROM
    xact(1, 8'h30, 4, 32'hFFFF_FFFE, "R9 rom probe");
    xact(0, 8'h30, 4, 0, "R9 rom probe read");
    xact(1, 8'h30, 4, 32'h1234_0001, "R9 rom value");
    xact(0, 8'h30, 4, 0, "R9 rom value read");
    // R10 legacy BAR
    xact(0, 8'h18, 4, 0, "R10 legacy read");
    xact(1, 8'h18, 4, 32'h5000_0000, "R10 legacy write");
    xact(1, 8'h18, 4, 32'hFFFF_FFFF, "R10 legacy probe");
    xact(0, 8'h18, 4, 0, "R10 legacy readback");

    done = 1;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule